// File: doc/BRIEF.md
# Dithered PWM Resolution Extender

This block drives one LED output with an effective 16-bit intensity code while its PWM engine counts only 14 bits. The 16-bit code is split into a 14-bit base and a 2-bit fraction. The block plays the base out over a group of four consecutive PWM frames. The fraction chooses which of those frames are stretched by one extra clock of on-time. Averaged over a group, the light output therefore matches the full 16-bit value.

Each frame is played out as a fixed number of identical subframes before the sequence moves on. A new code arrives with a valid strobe and is held aside. It is applied only when a fresh group begins, so a single group never blends two codes. The frame and subframe indices and a group-start pulse are brought out so that the sequencing can be observed. The period width and the subframe count are parameters: BASE_W = 14 and SUB_W = 5 by default, giving 32 subframes.

Top module: `pwm_dither_ext`

## Requirements
- R1: A synchronous active-high reset clears the period counter, the subframe and frame indices, the pending code and the active code. While reset is high and during the first group after it, pwm_out stays low and frame_idx and subframe_idx read 0.
- R2: The frame code is the active code's upper BASE_W bits plus an increment chosen by the frame index. Frame 0 adds 0. Frame 1 adds fraction bit 1. Frame 2 adds the OR of the two fraction bits. Frame 3 adds their AND. Fraction bit 1 is code bit 1, and fraction bit 0 is code bit 0.
- R3: Each frame lasts 2^BASE_W clocks. pwm_out is high while the free-running period counter is below the frame code, so a frame code of N gives exactly N on-clocks starting at the first clock of the period.
- R4: When the base is all ones and the increment is 1, the frame code saturates at 2^BASE_W-1 instead of wrapping. The output is therefore never high for a whole period.
- R5: Each frame repeats for 2^SUB_W subframes. subframe_idx counts 0 up to 2^SUB_W-1, and frame_idx then steps in the order 0, 1, 2, 3 and back to 0.
- R6: group_start is high for exactly the first clock of each group, which is frame 0, subframe 0, counter 0.
- R7: A code presented with code_valid is stored as the pending code. If several are presented, the last one wins. The pending code becomes active at the next group start. A code loaded in the middle of a group does not change that group.
- R8: When no frame saturates, a group carries 2^SUB_W × (4×base + 2×bit1 + bit0) on-clocks in total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| code_in | input | BASE_W+2 | Intensity code, 16 bits by default |
| code_valid | input | 1 | Strobe that stores code_in as the pending code |
| pwm_out | output | 1 | LED drive |
| group_start | output | 1 | High on the first clock of each four-frame group |
| frame_idx | output | 2 | Current frame within the group |
| subframe_idx | output | SUB_W | Current subframe within the frame |

## Verification
The bench counts the on-clocks of every subframe and compares them with the frame codes worked out for all four fraction patterns. A mistake in the increment rule would light the wrong frames while possibly keeping the group total. The all-ones base with full fraction is driven to catch a frame code that wraps to zero and goes dark. The bench also loads a new code in the middle of a group. A design that applied that code at once would show a mixed group, and one that kept the first of two back-to-back loads would play a stale code. The index outputs are checked at each period start to catch frames that advance early or run out of order.

// File: rtl/pwm_dither_ext.sv
module pwm_dither_ext #(
  parameter int BASE_W = 14,
  parameter int SUB_W  = 5,
  localparam int CODE_W = BASE_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code_in,
  input  logic              code_valid,
  output logic              pwm_out,
  output logic              group_start,
  output logic [1:0]        frame_idx,
  output logic [SUB_W-1:0]  subframe_idx
);

  logic [BASE_W-1:0] cnt;
  logic [SUB_W-1:0]  sub;
  logic [1:0]        frm;
  logic [CODE_W-1:0] hold, cur;
  logic [CODE_W-1:0] hold_nxt;
  logic              inc;
  logic [BASE_W:0]   sum;
  logic [BASE_W-1:0] fcode;

  assign hold_nxt = code_valid ? code_in : hold;

  always_comb begin
    case (frm)
      2'd0: inc = 1'b0;
      2'd1: inc = cur[1];
      2'd2: inc = cur[1] | cur[0];
      default: inc = cur[1] & cur[0];
    endcase
  end

  assign sum   = {1'b0, cur[CODE_W-1:2]} + {{BASE_W{1'b0}}, inc};
  assign fcode = sum[BASE_W] ? {BASE_W{1'b1}} : sum[BASE_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      sub  <= '0;
      frm  <= '0;
      hold <= '0;
      cur  <= '0;
    end else begin
      hold <= hold_nxt;
      cnt  <= cnt + 1'b1;
      if (&cnt) begin
        sub <= sub + 1'b1;
        if (&sub) begin
          frm <= frm + 2'd1;
          if (&frm) cur <= hold_nxt;
        end
      end
    end
  end

  assign pwm_out      = cnt < fcode;
  assign group_start  = (cnt == '0) && (sub == '0) && (frm == 2'd0);
  assign frame_idx    = frm;
  assign subframe_idx = sub;

endmodule

// File: rtl/pwm_dither_ext_chk.sv
module pwm_dither_ext_chk #(
  parameter int BASE_W = 14,
  parameter int SUB_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [BASE_W-1:0] cnt,
  input logic [BASE_W+1:0] cur,
  input logic              pwm_out,
  input logic              group_start,
  input logic [1:0]        frame_idx,
  input logic [SUB_W-1:0]  subframe_idx
);

  assert_frame_step_R5: assert property (@(posedge clk) disable iff (rst)
    (frame_idx != $past(frame_idx)) |->
      ($past(subframe_idx) == {SUB_W{1'b1}} && frame_idx == 2'($past(frame_idx) + 2'd1)));

  assert_group_origin_R6: assert property (@(posedge clk) disable iff (rst)
    group_start |-> (frame_idx == 2'd0 && subframe_idx == '0));

  assert_never_full_on_R4: assert property (@(posedge clk) disable iff (rst)
    (cnt == {BASE_W{1'b1}}) |-> !pwm_out);

  assert_code_swap_at_group_R7: assert property (@(posedge clk) disable iff (rst)
    (cur != $past(cur)) |-> group_start);

endmodule

bind pwm_dither_ext pwm_dither_ext_chk #(.BASE_W(BASE_W), .SUB_W(SUB_W)) u_chk (
  .clk(clk), .rst(rst), .cnt(cnt), .cur(cur), .pwm_out(pwm_out),
  .group_start(group_start), .frame_idx(frame_idx), .subframe_idx(subframe_idx)
);

// File: tb/pwm_dither_ext_bench.sv
module pwm_dither_ext_bench;
  localparam int BW = 4;
  localparam int SW = 1;
  localparam int CW = BW + 2;
  localparam int PER = 1 << BW;
  localparam int NSUB = 1 << SW;
  localparam int GRP = 4 * NSUB * PER;

  logic clk = 1'b0, rst = 1'b1, code_valid = 1'b0;
  logic [CW-1:0] code_in = '0;
  logic pwm_out, group_start;
  logic [1:0] frame_idx;
  logic [SW-1:0] subframe_idx;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  pwm_dither_ext #(.BASE_W(BW), .SUB_W(SW)) u_pwm_dither_ext (
    .clk(clk), .rst(rst), .code_in(code_in), .code_valid(code_valid),
    .pwm_out(pwm_out), .group_start(group_start),
    .frame_idx(frame_idx), .subframe_idx(subframe_idx));

  function automatic int exp_on(input logic [CW-1:0] c, input int f);
    int b, i;
    b = int'(c[CW-1:2]);
    case (f)
      0: i = 0;
      1: i = int'(c[1]);
      2: i = int'(c[1] | c[0]);
      default: i = int'(c[1] & c[0]);
    endcase
    return (b + i > PER - 1) ? PER - 1 : b + i;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load(input logic [CW-1:0] c);
    @(negedge clk);
    code_in = c; code_valid = 1'b1;
    @(negedge clk);
    code_valid = 1'b0;
  endtask

  task automatic measure_group(input logic [CW-1:0] c, input bit inj, input logic [CW-1:0] inj_code,
                               input string req);
    int on[4][NSUB];
    int n, total, exp_total;
    n = 0;
    while (!group_start && n < 4 * GRP) begin @(negedge clk); n++; end
    check(group_start, {req, " R6 group_start found"}, int'(group_start), 1);
    foreach (on[f, s]) on[f][s] = 0;
    for (int i = 0; i < GRP; i++) begin
      int f, s, k;
      f = i / (NSUB * PER); s = (i / PER) % NSUB; k = i % PER;
      if (k == 0) begin
        check(frame_idx == 2'(f) && subframe_idx == SW'(s), {req, " R5 indices"},
              int'(frame_idx) * 100 + int'(subframe_idx), f * 100 + s);
        check(group_start == (i == 0), {req, " R6 pulse"}, int'(group_start), int'(i == 0));
      end
      if (pwm_out) begin
        on[f][s]++;
        check(k < exp_on(c, f), {req, " R3 on at start"}, k, exp_on(c, f));
      end
      if (inj && i == 20) begin code_in = inj_code; code_valid = 1'b1; end
      if (inj && i == 21) code_valid = 1'b0;
      @(negedge clk);
    end
    total = 0;
    for (int f = 0; f < 4; f++)
      for (int s = 0; s < NSUB; s++) begin
        check(on[f][s] == exp_on(c, f), {req, " R2 frame on-clocks"}, on[f][s], exp_on(c, f));
        total += on[f][s];
      end
    exp_total = 0;
    for (int f = 0; f < 4; f++) exp_total += NSUB * exp_on(c, f);
    check(total == exp_total, {req, " R8 group total"}, total, exp_total);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check(!pwm_out && frame_idx == 0 && subframe_idx == 0, "R1 held in reset",
          int'(pwm_out), 0);
    rst = 1'b0;
    measure_group('0, 1'b0, '0, "R1 first group dark");
  endtask

  task automatic t_patterns;
    for (int l = 0; l < 4; l++) begin
      logic [CW-1:0] c;
      c = {4'd5, 2'(l)};
      load(c);
      measure_group(c, 1'b0, '0, "R2 fraction pattern");
      check(NSUB * (4 * 5 + 2 * (l >> 1) + (l & 1)) ==
            NSUB * (exp_on(c, 0) + exp_on(c, 1) + exp_on(c, 2) + exp_on(c, 3)),
            "R8 average rule", l, l);
    end
    load({4'd0, 2'd3});
    measure_group({4'd0, 2'd3}, 1'b0, '0, "R3 zero base");
  endtask

  task automatic t_saturate;
    load({4'hF, 2'd3});
    measure_group({4'hF, 2'd3}, 1'b0, '0, "R4 saturate");
  endtask

  task automatic t_midgroup;
    load({4'd9, 2'd1});
    measure_group({4'd9, 2'd1}, 1'b1, {4'd2, 2'd2}, "R7 mid-group load ignored");
    measure_group({4'd2, 2'd2}, 1'b0, '0, "R7 applied next group");
    @(negedge clk);
    code_in = {4'd1, 2'd0}; code_valid = 1'b1;
    @(negedge clk);
    code_in = {4'd12, 2'd3};
    @(negedge clk);
    code_valid = 1'b0;
    measure_group({4'd12, 2'd3}, 1'b0, '0, "R7 last load wins");
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_patterns();
    t_saturate();
    t_midgroup();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule